// File: doc/BRIEF.md
# Dual-Port Interprocessor Doorbell Mailbox

This block lets two processors ring doorbells at each other. Each processor reaches it through its own APB slave port. Both ports run on one shared clock and reset. There are three channels in each direction: a low-priority channel, a high-priority channel, and a channel reserved for secure traffic. Each channel holds a 32-bit status word.

A sender rings the remote side by writing bits into a write-to-set register in its transmit window. The same storage is the receive status on the other port. A nonzero receive status holds that port's level interrupt for the channel high. The receiver reads its receive status and writes the same value back to its write-to-clear register to acknowledge. The sender learns that the message was taken by polling its transmit status until it reads zero. There is no completion interrupt.

Non-secure accesses to the secure channel are refused. The block also returns a fixed identification value through four byte-wide registers.

Top module: `ipc_doorbell_mbox`

## Requirements
- R1: After reset, every status word is zero and every interrupt output is low.
- R2: The byte offsets of the receive windows are 0x000 for channel 0, 0x020 for channel 1 and 0x200 for channel 2. Each transmit window sits 0x100 above its channel's receive window. Inside a window, the status register is at +0x0, write-to-set at +0x8 and write-to-clear at +0x10. Reads of set or clear registers return zero. Unmapped offsets read zero with no error. pready is always 1, so there are no wait states.
- R3: A write to a set register ORs the written bits into the status word.
- R4: A write to a clear register removes the written bits. When the receiver writes back the value it read, the status reads zero on both sides.
- R5: Port A's transmit status for channel n is the same word as port B's receive status for channel n, and the reverse holds too. The channels are independent of each other.
- R6: Interrupt bit n of a port is high exactly while that port's receive status for channel n is nonzero.
- R7: When a set and a clear reach the same word in the same cycle, the clear is applied first and the set second, so the set bits survive.
- R8: A port may clear its own transmit status through its transmit clear register.
- R9: An access to channel 2 offsets with pprot[1]=1 (non-secure) reads zero, leaves the word unchanged and asserts pslverr in the access phase. Accesses with pprot[1]=0 work normally.
- R10: Offsets 0xFE0, 0xFE4, 0xFE8 and 0xFEC return one byte each of the identification value 0x001BB098, lowest byte first: 0x98, 0xB0, 0x1B, 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low reset |
| a_psel | input | 1 | Port A select |
| a_penable | input | 1 | Port A access phase |
| a_pwrite | input | 1 | Port A write strobe |
| a_paddr | input | 12 | Port A byte address |
| a_pwdata | input | 32 | Port A write data |
| a_pprot | input | 3 | Port A protection; bit 1 set means non-secure |
| a_prdata | output | 32 | Port A read data |
| a_pready | output | 1 | Port A ready (always 1) |
| a_pslverr | output | 1 | Port A error for refused secure access |
| a_irq | output | 3 | Port A per-channel receive interrupts |
| b_psel | input | 1 | Port B select |
| b_penable | input | 1 | Port B access phase |
| b_pwrite | input | 1 | Port B write strobe |
| b_paddr | input | 12 | Port B byte address |
| b_pwdata | input | 32 | Port B write data |
| b_pprot | input | 3 | Port B protection; bit 1 set means non-secure |
| b_prdata | output | 32 | Port B read data |
| b_pready | output | 1 | Port B ready (always 1) |
| b_pslverr | output | 1 | Port B error for refused secure access |
| b_irq | output | 3 | Port B per-channel receive interrupts |

## Verification
The bench drives a set from one port and a clear of the same word from the other port in the same cycle. A design that applied the clear after the set would lose the new doorbell bit and read back zero. It also writes to each channel's window and reads the opposite port's mirror. A decoder with a swapped direction or a wrong offset would show bits on the wrong channel, or raise the wrong interrupt bit. Non-secure writes and clears aimed at the secure channel are followed by secure reads. A gate that only blocked reads would show changed contents, and a missing error flag is caught in the access phase of the refused transfer.

// File: rtl/dbmb_pkg.sv
package dbmb_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 12;
  localparam int NCH    = 3;
  localparam int SEC_CH = 2;
  localparam logic [ADDR_W-1:0] TX_GAP = 12'h100;

  typedef enum logic [1:0] {K_NONE, K_STAT, K_SET, K_CLR} reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic        tx;
    logic [1:0]  ch;
    logic        id;
    logic [1:0]  id_idx;
  } dec_t;

  // Receive window base of a channel; the order is fixed by software.
  function automatic logic [ADDR_W-1:0] chan_base(input int ch);
    case (ch)
      0:       return 12'h000;
      1:       return 12'h020;
      default: return 12'h200;
    endcase
  endfunction

  function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a);
    dec_t d;
    logic [ADDR_W-1:0] b;
    d = '0;
    for (int ch = 0; ch < NCH; ch++) begin
      for (int w = 0; w < 2; w++) begin
        b = chan_base(ch) + ((w == 1) ? TX_GAP : 12'h000);
        if (a == b || a == b + 12'h008 || a == b + 12'h010) begin
          d.kind = (a == b) ? K_STAT : ((a == b + 12'h008) ? K_SET : K_CLR);
          d.tx   = (w == 1);
          d.ch   = 2'(ch);
        end
      end
    end
    if (a[11:4] == 8'hFE && a[1:0] == 2'b00) begin
      d.id     = 1'b1;
      d.id_idx = a[3:2];
    end
    return d;
  endfunction

  function automatic logic [7:0] id_byte(input logic [31:0] id, input logic [1:0] idx);
    return id[{idx, 3'b000} +: 8];
  endfunction

  // Clear first, set second.
  function automatic logic [WORD_W-1:0] merge_bits(input logic [WORD_W-1:0] cur,
                                                   input logic [WORD_W-1:0] clr,
                                                   input logic [WORD_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/dbmb_cell.sv
module dbmb_cell
  import dbmb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] set_src,
  input  logic [WORD_W-1:0] clr_src,
  input  logic [WORD_W-1:0] set_dst,
  input  logic [WORD_W-1:0] clr_dst,
  output logic [WORD_W-1:0] word,
  output logic              irq
);
  logic [WORD_W-1:0] set_all, clr_all;
  logic              touch;

  assign set_all = set_src | set_dst;
  assign clr_all = clr_src | clr_dst;
  assign touch   = (set_all != '0) || (clr_all != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word <= '0;
    else if (touch) word <= merge_bits(word, clr_all, set_all);
  end

  assign irq = |word;

  // R3
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_all != '0) |=> ((word & $past(set_all)) == $past(set_all)));
  // R4
  clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all != '0 && set_all == '0) |=> ((word & $past(clr_all)) == '0));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !touch |=> $stable(word));
  // R6
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(clr_all != '0));
endmodule

// File: rtl/dbmb_port_dec.sv
module dbmb_port_dec
  import dbmb_pkg::*;
#(
  parameter logic [31:0] PERIPH_ID = 32'h001BB098
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       psel,
  input  logic                       penable,
  input  logic                       pwrite,
  input  logic [ADDR_W-1:0]          paddr,
  input  logic [WORD_W-1:0]          pwdata,
  input  logic [2:0]                 pprot,
  input  logic [NCH-1:0][WORD_W-1:0] rx_word,
  input  logic [NCH-1:0][WORD_W-1:0] tx_word,
  output logic [NCH-1:0][WORD_W-1:0] rx_set,
  output logic [NCH-1:0][WORD_W-1:0] rx_clr,
  output logic [NCH-1:0][WORD_W-1:0] tx_set,
  output logic [NCH-1:0][WORD_W-1:0] tx_clr,
  output logic [WORD_W-1:0]          prdata,
  output logic                       pslverr
);
  dec_t d;
  logic access, sec_hit, wr_ok, rd_ok;
  logic unused_prot;

  assign d           = decode_addr(paddr);
  assign access      = psel & penable;
  assign sec_hit     = (d.kind != K_NONE) && (d.ch == 2'(SEC_CH)) && pprot[1];
  assign wr_ok       = access & pwrite & ~sec_hit;
  assign rd_ok       = access & ~pwrite & ~sec_hit;
  assign unused_prot = pprot[0] ^ pprot[2];

  for (genvar c = 0; c < NCH; c++) begin : g_strb
    logic hit;
    assign hit       = wr_ok && (d.ch == 2'(c));
    assign rx_set[c] = (hit && !d.tx && d.kind == K_SET) ? pwdata : '0;
    assign rx_clr[c] = (hit && !d.tx && d.kind == K_CLR) ? pwdata : '0;
    assign tx_set[c] = (hit &&  d.tx && d.kind == K_SET) ? pwdata : '0;
    assign tx_clr[c] = (hit &&  d.tx && d.kind == K_CLR) ? pwdata : '0;
  end

  always_comb begin
    prdata = '0;
    if (rd_ok) begin
      if (d.kind == K_STAT) begin
        for (int c = 0; c < NCH; c++)
          if (d.ch == 2'(c)) prdata = d.tx ? tx_word[c] : rx_word[c];
      end else if (d.id) begin
        prdata = {{(WORD_W-8){1'b0}}, id_byte(PERIPH_ID, d.id_idx)};
      end
    end
  end

  assign pslverr = access & sec_hit;

  // R9
  sec_noeffect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pslverr |-> (rx_set == '0 && rx_clr == '0 && tx_set == '0 && tx_clr == '0));
  // R9
  sec_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pslverr |-> (prdata == '0));
endmodule

// File: rtl/ipc_doorbell_mbox.sv
module ipc_doorbell_mbox
  import dbmb_pkg::*;
#(
  parameter logic [31:0] PERIPH_ID = 32'h001BB098
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_psel,
  input  logic              a_penable,
  input  logic              a_pwrite,
  input  logic [ADDR_W-1:0] a_paddr,
  input  logic [WORD_W-1:0] a_pwdata,
  input  logic [2:0]        a_pprot,
  output logic [WORD_W-1:0] a_prdata,
  output logic              a_pready,
  output logic              a_pslverr,
  output logic [NCH-1:0]    a_irq,
  input  logic              b_psel,
  input  logic              b_penable,
  input  logic              b_pwrite,
  input  logic [ADDR_W-1:0] b_paddr,
  input  logic [WORD_W-1:0] b_pwdata,
  input  logic [2:0]        b_pprot,
  output logic [WORD_W-1:0] b_prdata,
  output logic              b_pready,
  output logic              b_pslverr,
  output logic [NCH-1:0]    b_irq
);
  // ab_word: A transmits, B receives; ba_word: the other way.
  logic [NCH-1:0][WORD_W-1:0] ab_word, ba_word;
  logic [NCH-1:0][WORD_W-1:0] a_rx_set, a_rx_clr, a_tx_set, a_tx_clr;
  logic [NCH-1:0][WORD_W-1:0] b_rx_set, b_rx_clr, b_tx_set, b_tx_clr;

  assign a_pready = 1'b1;
  assign b_pready = 1'b1;

  dbmb_port_dec #(.PERIPH_ID(PERIPH_ID)) u_dec_a (
    .clk(clk), .rst_n(rst_n), .psel(a_psel), .penable(a_penable), .pwrite(a_pwrite),
    .paddr(a_paddr), .pwdata(a_pwdata), .pprot(a_pprot),
    .rx_word(ba_word), .tx_word(ab_word),
    .rx_set(a_rx_set), .rx_clr(a_rx_clr), .tx_set(a_tx_set), .tx_clr(a_tx_clr),
    .prdata(a_prdata), .pslverr(a_pslverr));

  dbmb_port_dec #(.PERIPH_ID(PERIPH_ID)) u_dec_b (
    .clk(clk), .rst_n(rst_n), .psel(b_psel), .penable(b_penable), .pwrite(b_pwrite),
    .paddr(b_paddr), .pwdata(b_pwdata), .pprot(b_pprot),
    .rx_word(ab_word), .tx_word(ba_word),
    .rx_set(b_rx_set), .rx_clr(b_rx_clr), .tx_set(b_tx_set), .tx_clr(b_tx_clr),
    .prdata(b_prdata), .pslverr(b_pslverr));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dbmb_cell u_ab (
      .clk(clk), .rst_n(rst_n),
      .set_src(a_tx_set[c]), .clr_src(a_tx_clr[c]),
      .set_dst(b_rx_set[c]), .clr_dst(b_rx_clr[c]),
      .word(ab_word[c]), .irq(b_irq[c]));
    dbmb_cell u_ba (
      .clk(clk), .rst_n(rst_n),
      .set_src(b_tx_set[c]), .clr_src(b_tx_clr[c]),
      .set_dst(a_rx_set[c]), .clr_dst(a_rx_clr[c]),
      .word(ba_word[c]), .irq(a_irq[c]));
  end
endmodule

// File: tb/tb_ipc_doorbell_mbox.sv
module tb_ipc_doorbell_mbox;
  localparam logic [2:0] NS = 3'b010;
  localparam logic [2:0] SC = 3'b000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic a_psel = 0, a_penable = 0, a_pwrite = 0;
  logic [11:0] a_paddr = '0;
  logic [31:0] a_pwdata = '0;
  logic [2:0]  a_pprot = '0;
  logic [31:0] a_prdata;
  logic a_pready, a_pslverr;
  logic [2:0] a_irq;
  logic b_psel = 0, b_penable = 0, b_pwrite = 0;
  logic [11:0] b_paddr = '0;
  logic [31:0] b_pwdata = '0;
  logic [2:0]  b_pprot = '0;
  logic [31:0] b_prdata;
  logic b_pready, b_pslverr;
  logic [2:0] b_irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    int port; bit wr; logic [31:0] data; logic err; string tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  ipc_doorbell_mbox dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares in each access phase.
  task automatic mon(int port, logic [31:0] rd, logic err, logic rdy, bit wr);
    exp_t e;
    if (q.size() == 0) begin
      chk("scoreboard empty", 32'd1, 32'd0);
      return;
    end
    e = q.pop_front();
    chk({e.tag, " port"}, 32'(port), 32'(e.port));
    chk({e.tag, " pslverr"}, {31'd0, err}, {31'd0, e.err});
    chk("R2 pready", {31'd0, rdy}, 32'd1);
    if (!wr) chk({e.tag, " prdata"}, rd, e.data);
  endtask

  always @(negedge clk) begin
    if (a_psel && a_penable) mon(0, a_prdata, a_pslverr, a_pready, a_pwrite);
    if (b_psel && b_penable) mon(1, b_prdata, b_pslverr, b_pready, b_pwrite);
  end

  task automatic drive(int port, bit sel, bit en, bit wr, logic [11:0] ad,
                       logic [31:0] wd, logic [2:0] pr);
    if (port == 0) begin
      a_psel = sel; a_penable = en; a_pwrite = wr; a_paddr = ad; a_pwdata = wd; a_pprot = pr;
    end else begin
      b_psel = sel; b_penable = en; b_pwrite = wr; b_paddr = ad; b_pwdata = wd; b_pprot = pr;
    end
  endtask

  task automatic xfer(int port, bit wr, logic [11:0] ad, logic [31:0] wd,
                      logic [2:0] pr, logic [31:0] exp_d, logic exp_e, string tag);
    q.push_back('{port, wr, exp_d, exp_e, tag});
    @(posedge clk); #1; drive(port, 1, 0, wr, ad, wd, pr);
    @(posedge clk); #1; drive(port, 1, 1, wr, ad, wd, pr);
    @(posedge clk); #1; drive(port, 0, 0, 0, 12'h0, 32'h0, 3'h0);
  endtask

  task automatic wr(int port, logic [11:0] ad, logic [31:0] wd, logic [2:0] pr,
                    logic exp_e, string tag);
    xfer(port, 1, ad, wd, pr, 32'h0, exp_e, tag);
  endtask

  task automatic rd(int port, logic [11:0] ad, logic [2:0] pr, logic [31:0] exp_d,
                    logic exp_e, string tag);
    xfer(port, 0, ad, 32'h0, pr, exp_d, exp_e, tag);
  endtask

  // Both ports write in the same access cycle.
  task automatic wr2(logic [11:0] aa, logic [31:0] ad, logic [11:0] ba, logic [31:0] bd,
                     string tag);
    q.push_back('{0, 1'b1, 32'h0, 1'b0, tag});
    q.push_back('{1, 1'b1, 32'h0, 1'b0, tag});
    @(posedge clk); #1; drive(0, 1, 0, 1, aa, ad, NS); drive(1, 1, 0, 1, ba, bd, NS);
    @(posedge clk); #1; drive(0, 1, 1, 1, aa, ad, NS); drive(1, 1, 1, 1, ba, bd, NS);
    @(posedge clk); #1; drive(0, 0, 0, 0, 12'h0, 32'h0, 3'h0); drive(1, 0, 0, 0, 12'h0, 32'h0, 3'h0);
  endtask

  task automatic chk_irq(string tag, logic [2:0] ea, logic [2:0] eb);
    @(negedge clk);
    chk({tag, " a_irq"}, {29'd0, a_irq}, {29'd0, ea});
    chk({tag, " b_irq"}, {29'd0, b_irq}, {29'd0, eb});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      if (q.size() != 0) chk("scoreboard leftover", 32'(q.size()), 32'd0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk_irq("R1", 3'b000, 3'b000);
    rd(0, 12'h100, NS, 32'h0, 0, "R1 A tx0");
    rd(1, 12'h000, NS, 32'h0, 0, "R1 B rx0");
    rd(0, 12'h300, SC, 32'h0, 0, "R1 A tx2");
    // R5 mirror A->B, R6 interrupt
    wr(0, 12'h108, 32'h5, NS, 0, "R3 set");
    rd(1, 12'h000, NS, 32'h5, 0, "R5 B rx0");
    rd(0, 12'h100, NS, 32'h5, 0, "R5 A tx0");
    chk_irq("R6 ch0", 3'b000, 3'b001);
    // R3 OR
    wr(0, 12'h108, 32'h30, NS, 0, "R3 set2");
    rd(1, 12'h000, NS, 32'h5 | 32'h30, 0, "R3 or");
    // R2 set/clear registers read zero, unmapped offset
    rd(0, 12'h108, NS, 32'h0, 0, "R2 set reads 0");
    rd(1, 12'h010, NS, 32'h0, 0, "R2 clr reads 0");
    rd(0, 12'h004, NS, 32'h0, 0, "R2 unmapped");
    // R4 acknowledge by writing back
    wr(1, 12'h010, 32'h05, NS, 0, "R4 clr part");
    rd(0, 12'h100, NS, 32'h30, 0, "R4 partial");
    chk_irq("R6 still", 3'b000, 3'b001);
    wr(1, 12'h010, 32'h30, NS, 0, "R4 clr rest");
    rd(0, 12'h100, NS, 32'h0, 0, "R4 poll zero");
    chk_irq("R6 drop", 3'b000, 3'b000);
    // R5 B->A on channel 1
    wr(1, 12'h128, 32'hA000_0001, NS, 0, "R5 B set");
    rd(0, 12'h020, NS, 32'hA000_0001, 0, "R5 A rx1");
    rd(0, 12'h000, NS, 32'h0, 0, "R5 A rx0 indep");
    chk_irq("R6 ch1", 3'b010, 3'b000);
    // R7 same-cycle clear and set
    wr2(12'h030, 32'h1, 12'h128, 32'h1, "R7 collide");
    rd(0, 12'h020, NS, 32'hA000_0001, 0, "R7 set survives");
    wr2(12'h030, 32'hFFFF_FFFF, 12'h128, 32'h4, "R7 collide2");
    rd(1, 12'h120, NS, 32'h4, 0, "R7 clr then set");
    // R8 own transmit clear
    wr(1, 12'h130, 32'h4, NS, 0, "R8 self clr");
    rd(0, 12'h020, NS, 32'h0, 0, "R8 flushed");
    chk_irq("R8", 3'b000, 3'b000);
    // R9 secure channel gating
    wr(0, 12'h308, 32'hFF, NS, 1, "R9 ns write");
    rd(1, 12'h200, SC, 32'h0, 0, "R9 ns write ignored");
    chk_irq("R9 no irq", 3'b000, 3'b000);
    rd(0, 12'h300, NS, 32'h0, 1, "R9 ns read");
    wr(0, 12'h308, 32'hC, SC, 0, "R9 sec write");
    rd(1, 12'h200, NS, 32'h0, 1, "R9 ns read masked");
    rd(1, 12'h200, SC, 32'hC, 0, "R9 sec read");
    chk_irq("R9 irq", 3'b000, 3'b100);
    wr(1, 12'h210, 32'hC, NS, 1, "R9 ns clr");
    rd(1, 12'h200, SC, 32'hC, 0, "R9 ns clr ignored");
    wr(1, 12'h210, 32'hC, SC, 0, "R9 sec clr");
    chk_irq("R9 cleared", 3'b000, 3'b000);
    // R10 identification bytes
    rd(0, 12'hFE0, NS, 32'h98, 0, "R10 id0");
    rd(0, 12'hFE4, NS, 32'hB0, 0, "R10 id1");
    rd(0, 12'hFE8, NS, 32'h1B, 0, "R10 id2");
    rd(0, 12'hFEC, NS, 32'h00, 0, "R10 id3");
    rd(1, 12'hFE4, NS, 32'hB0, 0, "R10 id1 B");
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule